// File: doc/BRIEF.md
# Dual-Bank SRAM Controller with Switchable SECDED Lane

This block sits between a 32-bit synchronous bus and two behavioural RAM arrays, each 4096 locations deep and five bytes wide. Four byte lanes of every location always carry bus data. The fifth lane either holds a 7-bit single-error-correcting, double-error-detecting code for the word beside it, or becomes storage of its own. A mode input selects between the two uses.

With protection on, the block exposes a 32 KB word region. Reads return corrected data and pulse a flag for a corrected single-bit error or for an uncorrectable error. A write that does not set all four byte enables becomes a read-modify-write and stalls the bus for one cycle. With protection off, the same 32 KB region stores plain bytes. The fifth lanes of both arrays then appear as an extra 8 KB byte region whose offsets are spread over the two arrays and over both halves of each array.

Every accepted access gets its response one clock later. The mode input is expected to change only while no access is in flight.

Top module: `dual_lane_sram`

## Requirements
- R1: Bus addresses 0x0000 to 0x3FFF reach array 0 and 0x4000 to 0x7FFF reach array 1. The location is address bits [13:2]. Byte enable bit k governs bus data bits [8k+7:8k], which land in byte lane k of that location.
- R2: While idle, `ready` is high. An access is accepted on a clock edge where `req` and `ready` are both high. For an accepted read, `rvalid` is high and `rdata` is valid throughout the following cycle. `rvalid` is low after a write.
- R3: With protection on, a full write (`be` = 4'hF) stores a code in lane 4. Bits [5:0] are Hamming check bits: check bit i sits at codeword position 2^i, and the data bits fill the remaining positions 3 to 38 in ascending order. Bit 6 is even parity over the 32 data bits and the six check bits. Bit 7 is zero.
- R4: With protection on, a read of a word holding exactly one flipped bit (data or code) returns the corrected data and raises `err_single` together with `rvalid`. The stored word is not repaired, so a second read flags again.
- R5: With protection on, a read of a word holding two flipped bits raises `err_double` with the uncorrected data bits. The two flags never rise together.
- R6: With protection on, a write with `be` not equal to 4'hF merges the new bytes into the corrected stored word, re-encodes it, and writes it back. `ready` is low for exactly the one cycle after acceptance.
- R7: With protection off, addresses 0x8000 to 0x9FFF form a byte region with offset o. It uses array o[0] at location o[12:2] + 2048*o[1], in lane 4. A write stores `wdata[7:0]` only when `be[0]` is set. A read returns the byte on `rdata[7:0]` with upper bits zero.
- R8: With protection off, writes to the 32 KB region leave lane 4 unchanged, and both error flags stay low.
- R9: With protection on, an access to 0x8000 to 0x9FFF writes nothing. One cycle later it raises `bus_err`, and a read returns zero.
- R10: Addresses at 0xA000 and above raise `bus_err` in either mode, write nothing, and read as zero.
- R11: During and right after reset, `ready` is high and `rvalid`, `bus_err`, `err_single` and `err_double` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ecc_en | input | 1 | 1: lane 4 holds check codes; 0: lane 4 is the extra byte region |
| req | input | 1 | Access request |
| we | input | 1 | 1 write, 0 read |
| addr | input | 16 | Byte address |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| ready | output | 1 | Bus can accept an access this cycle |
| rvalid | output | 1 | Read response valid |
| rdata | output | 32 | Read data |
| err_single | output | 1 | Corrected single-bit error on this read |
| err_double | output | 1 | Uncorrectable error on this read |
| bus_err | output | 1 | Access was refused |

## Verification
Faults are injected only through the bus. The bench switches protection off, rewrites data bytes or the code byte through the extra region, then switches protection back on and reads. A decoder that mislocates the syndrome would return a wrong bit or the wrong flag. A design that repairs on read would stop flagging on the second read. Partial writes onto a single-error word catch a merge that skips correction, which would store the bad bit with a fresh code. A random mix of mode switches, offsets spread over both arrays and both location halves, and refused windows exposes any scramble slip or any write leaking from a refused access, because a shared byte model predicts every later read.

// File: rtl/dls_pkg.sv
package dls_pkg;

  localparam int DATA_W  = 32;
  localparam int HAM_W   = 6;
  localparam int CODE_W  = 7;
  localparam int LANES   = 5;
  localparam int WORD_W  = 8 * LANES;
  localparam int CW_LAST = DATA_W + HAM_W;  // highest Hamming position

  typedef enum logic [1:0] {RGN_MAIN, RGN_SPARE, RGN_NONE} rgn_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              dbl;
  } fix_t;

  // Hamming check bits: data fill the non power-of-two positions 3..38.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p <= CW_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < HAM_W; i++)
          if (((p >> i) & 1) != 0) c[i] = c[i] ^ d[j];
        j++;
      end
    end
    return c;
  endfunction

  function automatic logic [CODE_W-1:0] secded_code(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic fix_t secded_fix(input logic [DATA_W-1:0] d,
                                      input logic [CODE_W-1:0] code);
    fix_t r;
    logic [HAM_W-1:0] syn;
    logic ovr;
    int j;
    syn = ham_bits(d) ^ code[HAM_W-1:0];
    ovr = (^d) ^ (^code);
    r.data = d;
    r.single = 1'b0;
    r.dbl = 1'b0;
    if (ovr) begin
      if (syn > 6'(CW_LAST)) begin
        r.dbl = 1'b1;
      end else begin
        r.single = 1'b1;
        j = 0;
        for (int p = 1; p <= CW_LAST; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (syn == 6'(p)) r.data[j] = ~r.data[j];
            j++;
          end
        end
      end
    end else if (syn != '0) begin
      r.dbl = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [3:0]        be);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < 4; k++)
      m[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
    return m;
  endfunction

endpackage

// File: rtl/dls_addr_map.sv
module dls_addr_map
  import dls_pkg::*;
#(
  parameter int LOC_BITS = 12
) (
  input  logic [LOC_BITS+3:0] addr,
  output rgn_e                rgn,
  output logic                bank,
  output logic [LOC_BITS-1:0] loc
);
  localparam int AW = LOC_BITS + 4;

  logic [LOC_BITS:0] off;
  assign off = addr[LOC_BITS:0];

  always_comb begin
    rgn  = RGN_NONE;
    bank = 1'b0;
    loc  = '0;
    if (!addr[AW-1]) begin
      // word region: upper half picks the array
      rgn  = RGN_MAIN;
      bank = addr[AW-2];
      loc  = addr[AW-3:2];
    end else if (addr[AW-2:AW-3] == 2'b00) begin
      // spare byte region: interleaved across arrays and location halves
      rgn  = RGN_SPARE;
      bank = off[0];
      loc  = {off[1], off[LOC_BITS:2]};
    end
  end
endmodule

// File: rtl/dls_bank.sv
module dls_bank #(
  parameter int LOC_BITS = 12,
  parameter int LANES    = 5
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic                  we,
  input  logic [LANES-1:0]      lane_we,
  input  logic [LOC_BITS-1:0]   loc,
  input  logic [8*LANES-1:0]    wdata,
  output logic [8*LANES-1:0]    rdata
);
  localparam int DEPTH = 1 << LOC_BITS;

  logic [8*LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      for (int k = 0; k < LANES; k++)
        if (we && lane_we[k]) mem[loc][8*k +: 8] <= wdata[8*k +: 8];
      rdata <= mem[loc];
    end
  end
endmodule

// File: rtl/dls_secded.sv
module dls_secded
  import dls_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic [DATA_W-1:0] mrg_data,
  input  logic [3:0]        mrg_be,
  input  logic [DATA_W-1:0] full_data,
  output logic [DATA_W-1:0] fix_data,
  output logic              fix_single,
  output logic              fix_double,
  output logic [WORD_W-1:0] mrg_word,
  output logic [WORD_W-1:0] full_word
);
  fix_t              fx;
  logic [DATA_W-1:0] merged;

  always_comb begin
    fx         = secded_fix(raw[DATA_W-1:0], raw[DATA_W +: CODE_W]);
    fix_data   = fx.data;
    fix_single = fx.single;
    fix_double = fx.dbl;
    merged     = merge_bytes(fx.data, mrg_data, mrg_be);
    mrg_word   = {1'b0, secded_code(merged), merged};
    full_word  = {1'b0, secded_code(full_data), full_data};
  end
endmodule

// File: rtl/dual_lane_sram.sv
module dual_lane_sram
  import dls_pkg::*;
#(
  parameter int LOC_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ecc_en,
  input  logic                req,
  input  logic                we,
  input  logic [LOC_BITS+3:0] addr,
  input  logic [3:0]          be,
  input  logic [31:0]         wdata,
  output logic                ready,
  output logic                rvalid,
  output logic [31:0]         rdata,
  output logic                err_single,
  output logic                err_double,
  output logic                bus_err
);
  localparam int NBANK = 2;

  // request decode
  rgn_e                rgn;
  logic                m_bank;
  logic [LOC_BITS-1:0] m_loc;
  logic                a_err;
  logic                ev_accept;
  logic                ev_rmw_start;
  logic                rmw_now;

  // response stage
  logic                s_valid, s_we, s_rmw, s_spare, s_err, s_ecc, s_bank;
  logic [LOC_BITS-1:0] s_loc;
  logic [3:0]          s_be;
  logic [31:0]         s_wdata;

  // bank control
  logic [NBANK-1:0]    b_en;
  logic                b_we;
  logic [LANES-1:0]    b_mask;
  logic [LOC_BITS-1:0] b_loc;
  logic [WORD_W-1:0]   b_wd;
  logic [WORD_W-1:0]   b_q [NBANK];
  logic [WORD_W-1:0]   q_sel;

  // ecc datapath
  logic [31:0]         fix_data;
  logic                fix_single, fix_double;
  logic [WORD_W-1:0]   mrg_word, full_word;

  dls_addr_map #(.LOC_BITS(LOC_BITS)) u_map (
    .addr (addr),
    .rgn  (rgn),
    .bank (m_bank),
    .loc  (m_loc)
  );

  assign rmw_now      = s_valid & s_rmw;
  assign ready        = ~rmw_now;
  assign ev_accept    = req & ready;
  assign a_err        = (rgn == RGN_NONE) | ((rgn == RGN_SPARE) & ecc_en);
  assign ev_rmw_start = ev_accept & we & ecc_en & (rgn == RGN_MAIN) & ~(&be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_rmw   <= 1'b0;
      s_we    <= 1'b0;
      s_spare <= 1'b0;
      s_err   <= 1'b0;
      s_ecc   <= 1'b0;
      s_bank  <= 1'b0;
      s_loc   <= '0;
      s_be    <= '0;
      s_wdata <= '0;
    end else begin
      s_valid <= ev_accept;
      s_rmw   <= ev_rmw_start;
      if (ev_accept) begin
        s_we    <= we;
        s_spare <= (rgn == RGN_SPARE);
        s_err   <= a_err;
        s_ecc   <= ecc_en;
        s_bank  <= m_bank;
        s_loc   <= m_loc;
        s_be    <= be;
        s_wdata <= wdata;
      end
    end
  end

  always_comb begin
    b_en   = '0;
    b_we   = 1'b0;
    b_mask = '0;
    b_loc  = m_loc;
    b_wd   = '0;
    if (rmw_now) begin
      // second half of a partial protected write
      b_en[s_bank] = 1'b1;
      b_we         = 1'b1;
      b_mask       = '1;
      b_loc        = s_loc;
      b_wd         = mrg_word;
    end else if (ev_accept && !a_err) begin
      b_en[m_bank] = 1'b1;
      if (we) begin
        if (rgn == RGN_SPARE) begin
          b_we   = be[0];
          b_mask = 5'b10000;
          b_wd   = {wdata[7:0], 32'h0};
        end else if (ecc_en) begin
          b_we   = &be;            // partial: read now, write next cycle
          b_mask = '1;
          b_wd   = full_word;
        end else begin
          b_we   = 1'b1;
          b_mask = {1'b0, be};
          b_wd   = {8'h00, wdata};
        end
      end
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    dls_bank #(.LOC_BITS(LOC_BITS), .LANES(LANES)) u_bank (
      .clk     (clk),
      .en      (b_en[g]),
      .we      (b_we),
      .lane_we (b_mask),
      .loc     (b_loc),
      .wdata   (b_wd),
      .rdata   (b_q[g])
    );
  end

  assign q_sel = s_bank ? b_q[1] : b_q[0];

  dls_secded u_ecc (
    .raw        (q_sel),
    .mrg_data   (s_wdata),
    .mrg_be     (s_be),
    .full_data  (wdata),
    .fix_data   (fix_data),
    .fix_single (fix_single),
    .fix_double (fix_double),
    .mrg_word   (mrg_word),
    .full_word  (full_word)
  );

  assign rvalid     = s_valid & ~s_we;
  assign bus_err    = s_valid & s_err;
  assign err_single = rvalid & s_ecc & ~s_spare & ~s_err & fix_single;
  assign err_double = rvalid & s_ecc & ~s_spare & ~s_err & fix_double;

  always_comb begin
    if (!rvalid || s_err)  rdata = '0;
    else if (s_spare)      rdata = {24'h0, q_sel[39:32]};
    else if (s_ecc)        rdata = fix_data;
    else                   rdata = q_sel[31:0];
  end
endmodule

// File: rtl/dual_lane_sram_chk.sv
module dual_lane_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ecc_en,
  input logic        we,
  input logic        ready,
  input logic        rvalid,
  input logic [31:0] rdata,
  input logic        err_single,
  input logic        err_double,
  input logic        bus_err,
  input logic        ev_accept,
  input logic        ev_rmw_start
);
  p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !we) |=> rvalid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_accept |=> (!rvalid && !bus_err));

  p_rmw_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_start |=> !ready);

  p_stall_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_single && err_double));

  p_flag_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_single || err_double) |-> rvalid);

  p_off_no_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ecc_en) |=> (!err_single && !err_double));

  p_refused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && rvalid) |-> (rdata == 32'h0));
endmodule

bind dual_lane_sram dual_lane_sram_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ecc_en       (ecc_en),
  .we           (we),
  .ready        (ready),
  .rvalid       (rvalid),
  .rdata        (rdata),
  .err_single   (err_single),
  .err_double   (err_double),
  .bus_err      (bus_err),
  .ev_accept    (ev_accept),
  .ev_rmw_start (ev_rmw_start)
);

// File: tb/sim_dual_lane_sram.sv
`timescale 1ns/1ps
module sim_dual_lane_sram;

  typedef struct packed {
    logic [31:0] d;
    logic        s;
    logic        dd;
  } bdec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ecc_en = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ready, rvalid, err_single, err_double, bus_err;
  logic [31:0] rdata;

  int  n_checks = 0;
  int  n_err = 0;
  bit  done = 0;

  logic [39:0] mdl [2][4096];

  always #2 clk = ~clk;

  dual_lane_sram u0 (
    .clk (clk), .rst_n (rst_n), .ecc_en (ecc_en), .req (req), .we (we),
    .addr (addr), .be (be), .wdata (wdata), .ready (ready), .rvalid (rvalid),
    .rdata (rdata), .err_single (err_single), .err_double (err_double),
    .bus_err (bus_err)
  );

  // codeword position of data bit j: j-th integer above 2 that is no power of two
  function automatic int pos_of(input int j);
    int n = -1;
    for (int p = 3; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) n++;
      if (n == j && (p & (p - 1)) != 0) return p;
    end
    return 0;
  endfunction

  function automatic logic [6:0] b_enc(input logic [31:0] d);
    logic [5:0] c = '0;
    for (int j = 0; j < 32; j++) begin
      int pp = pos_of(j);
      for (int i = 0; i < 6; i++) if (((pp >> i) & 1) != 0) c[i] = c[i] ^ d[j];
    end
    return {(^d) ^ (^c), c};
  endfunction

  // brute force: clean, or one flipped bit of 39 restores a valid codeword
  function automatic bdec_t b_dec(input logic [39:0] w);
    bdec_t r;
    logic [38:0] cw, t;
    cw = w[38:0];
    r.d = w[31:0]; r.s = 1'b0; r.dd = 1'b0;
    if (b_enc(cw[31:0]) == cw[38:32]) return r;
    for (int k = 0; k < 39; k++) begin
      t = cw;
      t[k] = ~t[k];
      if (b_enc(t[31:0]) == t[38:32]) begin
        r.d = t[31:0]; r.s = 1'b1;
        return r;
      end
    end
    r.dd = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] b_merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] b);
    logic [31:0] m = o;
    for (int k = 0; k < 4; k++) if (b[k]) m[8*k +: 8] = n[8*k +: 8];
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] got,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    ecc_en = m;
    @(negedge clk);
  endtask

  // one access; starts and ends just after a falling edge
  task automatic run_op(input bit w, input logic [15:0] a, input logic [3:0] b,
                        input logic [31:0] d, input string tag);
    logic [37:0] got, exp;
    logic [39:0] word;
    logic [31:0] nw, erd;
    bdec_t dc;
    bit main_r, spare_r, bad, stall, ese, ede;
    int bk, lc, o;
    logic r1, r2;
    main_r  = a < 16'h8000;
    spare_r = !main_r && a < 16'hA000;
    bad     = !(main_r || spare_r) || (spare_r && ecc_en);
    erd = '0; ese = 0; ede = 0; stall = 0; bk = 0; lc = 0;
    if (!bad) begin
      if (main_r) begin
        bk = a / 16384; lc = (a % 16384) / 4;
      end else begin
        o = a - 16'h8000;
        bk = o % 2; lc = (o / 4) % 2048 + ((o / 2) % 2) * 2048;
      end
      word = mdl[bk][lc];
      if (main_r && ecc_en) begin
        if (!w) begin
          dc = b_dec(word); erd = dc.d; ese = dc.s; ede = dc.dd;
        end else if (b == 4'hF) begin
          mdl[bk][lc] = {1'b0, b_enc(d), d};
        end else begin
          dc = b_dec(word); stall = 1;
          nw = b_merge(dc.d, d, b);
          mdl[bk][lc] = {1'b0, b_enc(nw), nw};
        end
      end else if (main_r) begin
        if (!w) erd = word[31:0];
        else mdl[bk][lc] = {word[39:32], b_merge(word[31:0], d, b)};
      end else begin
        if (!w) erd = {24'h0, word[39:32]};
        else if (b[0]) mdl[bk][lc] = {d[7:0], word[31:0]};
      end
    end
    req = 1'b1; we = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r1 = ready;
    got = {~r1, 1'b0, rvalid, bus_err, err_single, err_double, rdata};
    @(negedge clk);
    r2 = ready;
    got[36] = r2;
    exp = {stall, 1'b1, ~w, bad, ese, ede, erd};
    chk(got === exp, tag, {26'h0, got}, {26'h0, exp});
  endtask

  function automatic int pick_loc(input int idx);
    if (idx < 8)  return idx;
    if (idx < 16) return 2032 + idx;
    if (idx < 24) return 2032 + idx;
    return 4064 + idx;
  endfunction

  localparam logic [31:0] D0 = 32'hA5C3_1E70;

  initial begin
    void'($urandom(7717));
    repeat (2) @(negedge clk);
    chk(ready === 1'b1 && {rvalid, bus_err, err_single, err_double} === 4'b0, "R11 in reset",
        {59'h0, ready, rvalid, bus_err, err_single, err_double}, 64'h10);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1 && {rvalid, bus_err, err_single, err_double} === 4'b0, "R11 after reset",
        {59'h0, ready, rvalid, bus_err, err_single, err_double}, 64'h10);

    // fill the tested locations with clean protected words
    for (int bk = 0; bk < 2; bk++)
      for (int i = 0; i < 32; i++)
        run_op(1, 16'(bk * 16384 + pick_loc(i) * 4), 4'hF, $urandom, "R3 fill");

    // code byte layout seen through the extra region
    run_op(1, 16'h0010, 4'hF, D0, "R3 full write");
    run_op(0, 16'h0010, 4'h0, 0, "R1 read back");
    set_mode(1'b0);
    run_op(0, 16'h8010, 4'h0, 0, "R3 code byte");
    chk(mdl[0][4][39:32] === {1'b0, b_enc(D0)}, "R3 model code", {24'h0, mdl[0][4]},
        {24'h0, 1'b0, b_enc(D0), D0});

    // single data-bit fault, no repair on read
    run_op(1, 16'h0010, 4'h1, D0 ^ 32'h1, "R8 plain write");
    run_op(0, 16'h8010, 4'h0, 0, "R8 lane4 untouched");
    set_mode(1'b1);
    run_op(0, 16'h0010, 4'h0, 0, "R4 corrected");
    run_op(0, 16'h0010, 4'h0, 0, "R4 still flagged");

    // second fault makes it uncorrectable
    set_mode(1'b0);
    run_op(1, 16'h0012, 4'h4, D0 ^ 32'h0001_0001, "R8 plain write");
    set_mode(1'b1);
    run_op(0, 16'h0010, 4'h0, 0, "R5 double");

    // partial writes
    run_op(1, 16'h401C, 4'hF, 32'h1357_9BDF, "R3 full write");
    run_op(1, 16'h401C, 4'h2, 32'h0000_AA00, "R6 partial clean");
    run_op(0, 16'h401C, 4'h0, 0, "R6 merged");
    run_op(1, 16'h0008, 4'hF, 32'h0F0F_7777, "R3 full write");
    set_mode(1'b0);
    run_op(1, 16'h0008, 4'h8, 32'h8F00_0000, "R8 plain write");
    set_mode(1'b1);
    run_op(1, 16'h0008, 4'h1, 32'h0000_0042, "R6 partial on faulty");
    run_op(0, 16'h0008, 4'h0, 0, "R6 repaired by merge");

    // fault in the code byte
    run_op(1, 16'h000C, 4'hF, 32'hDEAD_0BEE, "R3 full write");
    set_mode(1'b0);
    run_op(1, 16'h800C, 4'h1, {24'h0, {1'b0, b_enc(32'hDEAD_0BEE)} ^ 8'h04}, "R7 code poke");
    set_mode(1'b1);
    run_op(0, 16'h000C, 4'h0, 0, "R4 code-bit fault");

    // refused windows
    run_op(0, 16'h8001, 4'h0, 0, "R9 read refused");
    run_op(1, 16'h8001, 4'h1, 32'h5A, "R9 write refused");
    run_op(0, 16'hA000, 4'h0, 0, "R10 read on");
    run_op(1, 16'hB123, 4'hF, 32'h1, "R10 write on");
    set_mode(1'b0);
    run_op(0, 16'h8001, 4'h0, 0, "R9 byte unchanged");
    run_op(0, 16'hFFFC, 4'h0, 0, "R10 read off");
    run_op(1, 16'hA004, 4'hF, 32'h2, "R10 write off");

    // extra region interleave
    for (int i = 0; i < 6; i++) run_op(1, 16'(16'h8000 + i), 4'h1, 32'(8'h11 * (i + 1)), "R7 write");
    run_op(1, 16'h8003, 4'hE, 32'hFF, "R7 be0 clear");
    for (int i = 0; i < 6; i++) run_op(0, 16'(16'h8000 + i), 4'h0, 0, "R7 read");
    set_mode(1'b1);
    run_op(0, 16'h2000, 4'h0, 0, "R7 spare hits loc 2048");
    run_op(1, 16'h0000, 4'hF, 32'h0000_1111, "R1 array0");
    run_op(1, 16'h4000, 4'hF, 32'h2222_0000, "R1 array1");
    run_op(0, 16'h0000, 4'h0, 0, "R1 array0 read");
    run_op(0, 16'h4000, 4'h0, 0, "R1 array1 read");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int kind, li, bk;
      bit w;
      logic [15:0] a;
      logic [3:0] b;
      string tag;
      if ($urandom % 16 == 0) set_mode(~ecc_en);
      kind = $urandom % 10;
      li = pick_loc($urandom % 32);
      bk = $urandom % 2;
      w = $urandom % 2;
      b = 4'($urandom);
      if (kind < 5) begin
        a = 16'(bk * 16384 + li * 4 + ($urandom % 4));
        tag = !ecc_en && w ? "R8 rnd" : (ecc_en && w && b != 4'hF) ? "R6 rnd" : "R1 rnd";
      end else if (kind < 9) begin
        a = 16'(16'h8000 + (li % 2048) * 4 + (li / 2048) * 2 + bk);
        tag = ecc_en ? "R9 rnd" : "R7 rnd";
      end else begin
        a = 16'(16'hA000 + ($urandom % 16'h6000));
        tag = "R10 rnd";
      end
      run_op(w, a, b, $urandom, tag);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule